// File: doc/BRIEF.md
# Burst Valid-Data Status Tracker

This block keeps a single status flag that tells the rest of a line interface whether a well-framed, error-free burst has recently come out of the demodulator. At the end of every burst the demodulator gives a one-cycle done pulse together with a sync-good and a bit-error indication. The tracker turns these into a burst verdict and decides when that verdict reaches the flag. The rule depends on the operating mode.

On the master side, with the line powered up, the flag moves only on recognized rising edges of the 8 kHz frame reference. On the master side, with the line powered down, the flag follows each burst verdict at once and decays to low after three frame edges with no new burst. On the slave side the flag follows each verdict at once and drops when no valid burst has arrived for a programmable number of system clocks (512 at 2.048 MHz, which is 250 µs). The frame reference is asynchronous and passes through a synchronizer before its rising edges are detected. The flag leaves the block on a pin that can be released to high impedance.

Top module: `burst_valid_tracker`

## Requirements
- R1: A burst verdict is valid only when `sync_ok_i` is 1 and `bit_err_i` is 0 in the same clock cycle as `burst_done_i`. Any other combination is an invalid verdict.
- R2: While `out_en_i` is 0, `valid_oe_o` is 0 and `valid_o` is released to high impedance. While `out_en_i` is 1, `valid_oe_o` is 1 and `valid_o` shows the flag. The flag state is not disturbed by the output enable.
- R3: In master mode (`slave_i`=0) with `pwr_on_i`=1, the flag changes only at a recognized frame edge. At that edge it takes the verdict of the latest burst accepted since the previous recognized frame edge, or 0 if there was no such burst. A burst whose done pulse falls in the same cycle as the recognized edge counts toward the next frame.
- R4: In master mode with `pwr_on_i`=0, the flag takes the burst verdict on the clock edge at which `burst_done_i` is sampled.
- R5: In master mode with `pwr_on_i`=0, the third recognized frame edge after the latest burst, with no burst in between, drives the flag to 0. The edge count saturates at three. A burst in the same cycle as a recognized edge wins and restarts the count.
- R6: In slave mode (`slave_i`=1), the flag takes each burst verdict at once. After a valid burst with no later valid burst, the flag stays 1 for exactly `TIMEOUT_CYC` clocks (default 512) and then falls to 0.
- R7: Synchronous active-high `rst` drives the flag to 0 and clears the pending verdict, the frame-edge count and the timeout count.
- R8: A rising edge of `frame_ref_i` is recognized two clocks after the first clock edge that samples it high. If it is first sampled high at edge n, the flag update it causes appears after edge n+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (2.048 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| burst_done_i | input | 1 | One-cycle pulse at end of a demodulated burst |
| sync_ok_i | input | 1 | Burst framing was correct (sampled with done) |
| bit_err_i | input | 1 | A bit error was seen in the burst (sampled with done) |
| frame_ref_i | input | 1 | Asynchronous 8 kHz frame reference |
| pwr_on_i | input | 1 | 1 = line powered up, 0 = powered down |
| out_en_i | input | 1 | 1 = drive the flag pin, 0 = release it |
| slave_i | input | 1 | 1 = slave mode, 0 = master mode |
| valid_o | inout | 1 | Valid-data flag, high impedance when disabled |
| valid_oe_o | output | 1 | Enable of the flag pin driver |

## Verification
The hardest case to reach from the ports is a burst done pulse that falls in exactly the cycle in which a frame edge is recognized. This matters in both master modes: it decides whether the verdict waits for the next frame and whether the three-edge decay restarts. The frame edge only shows up two clocks after the pin rises, so the bench drives the frame reference from a stepped phase counter and places the done pulse a counted number of steps after the rise. Long random runs in every mode, checked against a behavioural model on every clock, cover the timeout boundary and the collisions of the decay count.

// File: rtl/bvt_pkg.sv
package bvt_pkg;

  typedef enum logic [1:0] {
    UPD_SLAVE_TIMEOUT = 2'd0,
    UPD_MASTER_FRAME  = 2'd1,
    UPD_MASTER_EVENT  = 2'd2
  } upd_mode_e;

  function automatic upd_mode_e pick_mode(input logic slave, input logic pwr_on);
    if (slave)       return UPD_SLAVE_TIMEOUT;
    else if (pwr_on) return UPD_MASTER_FRAME;
    else             return UPD_MASTER_EVENT;
  endfunction

  function automatic logic burst_good(input logic sync_ok, input logic bit_err);
    return sync_ok & ~bit_err;
  endfunction

endpackage

// File: rtl/bvt_edge_detect.sv
module bvt_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // R8: a recognized edge is a single-cycle pulse
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/bvt_frame_expiry.sv
module bvt_frame_expiry #(
  parameter int EXPIRY_EDGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clear_i,
  input  logic edge_i,
  output logic expire_o
);
  localparam int FW = $clog2(EXPIRY_EDGES + 1);
  localparam logic [FW-1:0] TOP  = FW'(EXPIRY_EDGES);
  localparam logic [FW-1:0] LAST = FW'(EXPIRY_EDGES - 1);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || clear_i) cnt_q <= '0;
    else if (edge_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i & ~clear_i & edge_i & (cnt_q == LAST);

  // R5: expiry leaves the count saturated
  assert_expiry_sat_R5: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == TOP));
  // R5: once saturated, further edges keep it there
  assert_hold_top_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP && en_i && !clear_i) |=> (cnt_q == TOP));

endmodule

// File: rtl/bvt_slave_timer.sv
module bvt_slave_timer #(
  parameter int TIMEOUT_CYC = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic reload_i,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIM  = TW'(TIMEOUT_CYC);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reload_i) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i & ~reload_i & (cnt_q == LAST);

  // R6: a valid burst restarts the window
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (cnt_q == '0));
  // R6: expiry fires once per window
  assert_expire_once_R6: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

endmodule

// File: rtl/burst_valid_tracker.sv
module burst_valid_tracker #(
  parameter int TIMEOUT_CYC  = 512,
  parameter int EXPIRY_EDGES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_done_i,
  input  logic sync_ok_i,
  input  logic bit_err_i,
  input  logic frame_ref_i,
  input  logic pwr_on_i,
  input  logic out_en_i,
  input  logic slave_i,
  inout  wire  valid_o,
  output logic valid_oe_o
);
  import bvt_pkg::*;

  logic      frm_rise;
  logic      frm_exp;
  logic      slv_exp;
  logic      verdict;
  logic      flag_q;
  logic      pend_q;
  upd_mode_e mode;

  assign verdict = burst_good(sync_ok_i, bit_err_i);
  assign mode    = pick_mode(slave_i, pwr_on_i);

  bvt_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (frame_ref_i),
    .rise_o  (frm_rise)
  );

  bvt_frame_expiry #(.EXPIRY_EDGES(EXPIRY_EDGES)) u_fexp (
    .clk      (clk),
    .rst      (rst),
    .en_i     (mode == UPD_MASTER_EVENT),
    .clear_i  (burst_done_i),
    .edge_i   (frm_rise),
    .expire_o (frm_exp)
  );

  bvt_slave_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_stmr (
    .clk      (clk),
    .rst      (rst),
    .en_i     (mode == UPD_SLAVE_TIMEOUT),
    .reload_i (burst_done_i & verdict),
    .expire_o (slv_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      unique case (mode)
        UPD_SLAVE_TIMEOUT: begin
          if (burst_done_i) flag_q <= verdict;
          else if (slv_exp) flag_q <= 1'b0;
        end
        UPD_MASTER_FRAME: begin
          if (frm_rise) flag_q <= pend_q;
        end
        default: begin
          if (burst_done_i) flag_q <= verdict;
          else if (frm_exp) flag_q <= 1'b0;
        end
      endcase
      if (burst_done_i)  pend_q <= verdict;
      else if (frm_rise) pend_q <= 1'b0;
    end
  end

  assign valid_oe_o = out_en_i;
  assign valid_o    = out_en_i ? flag_q : 1'bz;

  // R3: frame-synchronous mode holds between recognized edges
  assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (rst)
    (!slave_i && pwr_on_i && !frm_rise) |=> $stable(flag_q));
  // R1: an invalid verdict in an immediate mode leaves the flag low
  assert_bad_burst_low_R1: assert property (@(posedge clk) disable iff (rst)
    (burst_done_i && !(sync_ok_i && !bit_err_i) && (slave_i || !pwr_on_i)) |=> !flag_q);
  // R4: event mode loads a good verdict at once
  assert_event_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!slave_i && !pwr_on_i && burst_done_i && sync_ok_i && !bit_err_i) |=> flag_q);
  // R7: reset clears the flag and pending verdict
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!flag_q && !pend_q));

endmodule

// File: tb/sim_burst_valid_tracker.sv
module sim_burst_valid_tracker;
  localparam int TMO = 512;
  localparam int FP  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done = 1'b0, sok = 1'b0, berr = 1'b0, fref = 1'b0;
  logic pwr = 1'b1, oe = 1'b1, slv = 1'b0;
  wire  valid_o;
  logic valid_oe_o;

  int tests = 0, fails = 0;
  bit finished = 0;
  bit frame_run = 0;
  int fphase = 0;
  string tag = "R7";

  // behavioural reference state
  int m_flag = 0, m_pend = 0, m_fcnt = 0, m_scnt = 0;
  int fhist[$];

  always #4 clk = ~clk;

  burst_valid_tracker u0 (
    .clk(clk), .rst(rst), .burst_done_i(done), .sync_ok_i(sok),
    .bit_err_i(berr), .frame_ref_i(fref), .pwr_on_i(pwr),
    .out_en_i(oe), .slave_i(slv), .valid_o(valid_o), .valid_oe_o(valid_oe_o)
  );

  task automatic chk(input string t, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", t, act, exp, $time);
    end
  endtask

  // reference model, advanced at every rising edge
  always @(posedge clk) begin
    int good, rise;
    int nflag;
    fhist.push_front(rst ? 0 : int'(fref));
    if (fhist.size() > 4) void'(fhist.pop_back());
    if (rst) begin
      m_flag = 0; m_pend = 0; m_fcnt = 0; m_scnt = 0;
    end else begin
      good = (done && sok && !berr) ? 1 : 0;
      rise = (fhist.size() == 4 && fhist[2] == 1 && fhist[3] == 0) ? 1 : 0;
      nflag = m_flag;
      if (slv) begin
        if (done) nflag = good;
        else if (m_scnt == TMO - 1) nflag = 0;
      end else if (pwr) begin
        if (rise) nflag = m_pend;
      end else begin
        if (done) nflag = good;
        else if (rise && m_fcnt == 2) nflag = 0;
      end
      if (done) m_pend = good;
      else if (rise) m_pend = 0;
      if (slv || pwr || done) m_fcnt = 0;
      else if (rise && m_fcnt < 3) m_fcnt++;
      if (done && good) m_scnt = 0;
      else if (m_scnt < TMO) m_scnt++;
      m_flag = nflag;
    end
  end

  // every-clock comparison, half a period after the edge
  always @(negedge clk) begin
    if (!finished) begin
      chk({"R2 oe ", tag}, int'(valid_oe_o), int'(oe));
      if (oe) chk({"flag ", tag}, int'(valid_o), m_flag);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    if (frame_run) begin
      fphase = (fphase + 1) % FP;
      fref = (fphase < FP / 2);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic burst(input logic s, input logic e);
    done = 1'b1; sok = s; berr = e;
    step();
    done = 1'b0; sok = 1'b0; berr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_run = 0; fref = 1'b0; fphase = 0;
    steps(3);
    rst = 1'b0;
  endtask

  // one frame rise, recognized two edges after first sampling
  task automatic frame_pulse();
    fref = 1'b1; steps(4); fref = 1'b0; steps(4);
  endtask

  task automatic random_run(input int n, input int gap_max);
    for (int i = 0; i < n; i++) begin
      int gap = $urandom_range(gap_max, 0);
      steps(gap);
      case ($urandom_range(3, 0))
        0: burst(1'b1, 1'b1);
        1: burst(1'b0, 1'b0);
        default: burst(1'b1, 1'b0);
      endcase
    end
  endtask

  initial begin
    // R7: reset state
    do_reset();
    tag = "R7";
    chk("R7 flag after reset", int'(valid_o), 0);

    // R2: release and re-enable keep the flag state
    slv = 1'b1; pwr = 1'b1; tag = "R2";
    burst(1'b1, 1'b0);
    oe = 1'b0; step();
    chk("R2 oe low", int'(valid_oe_o), 0);
    steps(5); oe = 1'b1; step();
    chk("R2 flag kept", int'(valid_o), 1);

    // R1 / R6 slave immediate and timeout boundary
    do_reset(); slv = 1'b1; tag = "R6";
    burst(1'b0, 1'b0);
    chk("R1 bad sync", int'(valid_o), 0);
    burst(1'b1, 1'b1);
    chk("R1 bit error", int'(valid_o), 0);
    burst(1'b1, 1'b0);
    chk("R1 good burst", int'(valid_o), 1);
    steps(TMO - 1);
    chk("R6 high at last cycle", int'(valid_o), 1);
    step();
    chk("R6 low at timeout", int'(valid_o), 0);
    burst(1'b1, 1'b0); steps(200); burst(1'b1, 1'b0); steps(TMO - 1);
    chk("R6 reload extends", int'(valid_o), 1);
    step();
    chk("R6 reload then expire", int'(valid_o), 0);
    frame_run = 1; random_run(60, 700);

    // R4 / R5 / R8 master powered-down
    do_reset(); slv = 1'b0; pwr = 1'b0; tag = "R5";
    burst(1'b1, 1'b0);
    chk("R4 immediate load", int'(valid_o), 1);
    frame_pulse(); frame_pulse();
    chk("R5 two edges keep", int'(valid_o), 1);
    fref = 1'b1; step(); step();
    chk("R8 not yet at n+1", int'(valid_o), 1);
    step();
    chk("R8 R5 low at n+2 third edge", int'(valid_o), 0);
    fref = 1'b0; steps(3);
    frame_pulse(); frame_pulse();
    chk("R5 saturated stays low", int'(valid_o), 0);
    // collision: burst in the cycle of the third recognized edge
    burst(1'b1, 1'b0); frame_pulse(); frame_pulse();
    fref = 1'b1; step(); step();
    burst(1'b1, 1'b0);
    chk("R5 burst wins over edge", int'(valid_o), 1);
    fref = 1'b0; steps(3);
    frame_pulse(); frame_pulse();
    chk("R5 count restarted", int'(valid_o), 1);
    frame_pulse();
    chk("R5 expire after restart", int'(valid_o), 0);
    tag = "R4";
    frame_run = 1; random_run(80, 130);

    // R3 master powered-up
    do_reset(); slv = 1'b0; pwr = 1'b1; tag = "R3";
    burst(1'b1, 1'b0);
    chk("R3 no change before edge", int'(valid_o), 0);
    frame_pulse();
    chk("R3 loads pending at edge", int'(valid_o), 1);
    frame_pulse();
    chk("R3 empty frame clears", int'(valid_o), 0);
    // collision: burst in the cycle of the recognized edge waits a frame
    fref = 1'b1; step(); step();
    burst(1'b1, 1'b0);
    chk("R3 collided burst deferred", int'(valid_o), 0);
    fref = 1'b0; steps(3); frame_pulse();
    chk("R3 collided burst next frame", int'(valid_o), 1);
    frame_run = 1; random_run(80, 90);

    // mode changes after random traffic, reset between
    do_reset(); slv = 1'b0; pwr = 1'b0; frame_run = 1; tag = "R5";
    random_run(40, 300);
    tag = "R3"; pwr = 1'b1; random_run(40, 60);
    step();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule